// File: doc/BRIEF.md
# Convolution Micro-Op Sequencer

This block walks the loop nest of a 2D convolution over channel-tiled NHWC data and emits, one per accepted transfer, the index triple that a matrix-multiply core needs for one accumulate step. Each triple names an accumulator slot (`dst`), an input tile (`src`) and a weight tile (`wgt`). Each step adds the product of one input-channel tile at one kernel tap into one output pixel and channel tile. The triples leave on a valid/ready stream. A flag marks the final one, so the stream can be written straight into micro-op storage or fed to the core.

The geometry is latched on a `start` pulse: map height and width, kernel height and width, and the output and input channel counts in tiles. The input buffer is assumed to be zero-padded to (h+kh-1)×(w+kw-1), and the output map has the same height and width as the input. The accumulator takes several cycles before a write becomes visible, so the emission order never gives two back-to-back steps the same accumulator slot. The output-tile loops run innermost and the reduction loops run outside them. A geometry for which that order cannot separate the slots is refused.

Top module: `conv_uop_seq`

## Requirements
- R1: While and just after reset, `uop_valid`, `busy` and `cfg_err` are 0.
- R2: A `start` seen while idle with a legal geometry latches the geometry, clears `cfg_err` and raises `busy` and `uop_valid` on the next cycle. The first triple is (0, 0, 0).
- R3: Let OCt and ICt be the tile counts and pw = w+kw-1. Then dst = (y·w+x)·OCt+oc, src = ((y+ky)·pw+(x+kx))·ICt+ic, and wgt = ((oc·kh+ky)·kw+kx)·ICt+ic.
- R4: Triples are emitted with y outermost, followed by ky, kx and ic, then x, and oc innermost. Each index counts up from 0.
- R5: Exactly h·w·kh·kw·OCt·ICt triples are transferred per run, and `uop_last` is 1 on the final one only.
- R6: Two consecutively transferred triples never carry the same dst.
- R7: While `uop_valid` is 1 and `uop_ready` is 0, the triple, `uop_last` and `uop_valid` hold unchanged into the next cycle.
- R8: A `start` while idle with any geometry field equal to 0, or with w·OCt equal to 1, sets `cfg_err` to 1 and emits nothing. `cfg_err` stays 1 until the next accepted start.
- R9: A `start` while busy is ignored, and the running sequence continues with its latched geometry.
- R10: One cycle after the final triple is transferred, `busy` and `uop_valid` are 0, and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence with the geometry on the cfg inputs |
| cfg_h | input | DIM_W | Map height |
| cfg_w | input | DIM_W | Map width |
| cfg_kh | input | DIM_W | Kernel height |
| cfg_kw | input | DIM_W | Kernel width |
| cfg_oct | input | DIM_W | Output channel tiles |
| cfg_ict | input | DIM_W | Input channel tiles |
| busy | output | 1 | A sequence is running |
| cfg_err | output | 1 | Last start was refused |
| uop_valid | output | 1 | Triple available |
| uop_ready | input | 1 | Consumer accepts the triple |
| uop_dst | output | IDX_W | Accumulator index |
| uop_src | output | IDX_W | Input buffer index |
| uop_wgt | output | IDX_W | Weight buffer index |
| uop_last | output | 1 | Final triple of the sequence |

## Verification
The hardest points to reach are the loop wraps where the dst chain could repeat. These are the seams where the inner (x, oc) pair rolls over into a new reduction step, and the edge geometries where w·OCt is exactly 2. The stimulus table covers a 1×1 map with two output tiles and a single-tile map row, and it also contains the full-size 9×9 case. A consumer that drops `uop_ready` every fourth cycle makes stalls land on every kind of counter wrap, including the last triple. A start pulse inserted mid-run with a different geometry checks that the latched values survive.

// File: rtl/conv_uop_pkg.sv
package conv_uop_pkg;

    // Width of every geometry field
    localparam int DIM_W = 8;
    // Number of nested loop counters
    localparam int NLOOP = 6;

    // Counter positions, innermost first
    localparam int L_OC = 0;
    localparam int L_X  = 1;
    localparam int L_IC = 2;
    localparam int L_KX = 3;
    localparam int L_KY = 4;
    localparam int L_Y  = 5;

    typedef logic [DIM_W-1:0] dim_t;

    typedef struct packed {
        dim_t h;
        dim_t w;
        dim_t kh;
        dim_t kw;
        dim_t oct;
        dim_t ict;
    } conv_geom_t;

    typedef logic [NLOOP-1:0][DIM_W-1:0] loop_vec_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Geometry that cannot keep consecutive dst values apart, or is empty
    function automatic logic geom_is_bad(conv_geom_t g);
        logic any_zero;
        any_zero = (g.h == '0) || (g.w == '0) || (g.kh == '0) ||
                   (g.kw == '0) || (g.oct == '0) || (g.ict == '0);
        return any_zero || ((g.w == dim_t'(1)) && (g.oct == dim_t'(1)));
    endfunction

    // Loop limits in counter order
    function automatic loop_vec_t geom_limits(conv_geom_t g);
        loop_vec_t lim;
        lim[L_OC] = g.oct;
        lim[L_X]  = g.w;
        lim[L_IC] = g.ict;
        lim[L_KX] = g.kw;
        lim[L_KY] = g.kh;
        lim[L_Y]  = g.h;
        return lim;
    endfunction

endpackage

// File: rtl/uop_loop_nest.sv
module uop_loop_nest
    import conv_uop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      advance,
    input  loop_vec_t limits,
    output loop_vec_t count,
    output logic      at_end
);

    logic [NLOOP:0]   carry;
    logic [NLOOP-1:0] at_top;

    assign carry[0] = advance;

    generate
        for (genvar i = 0; i < NLOOP; i++) begin : g_ctr
            dim_t ctr_q;

            assign at_top[i]   = (ctr_q == limits[i] - dim_t'(1));
            assign carry[i+1]  = carry[i] && at_top[i];
            assign count[i]    = ctr_q;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    ctr_q <= '0;
                end else if (carry[i]) begin
                    ctr_q <= at_top[i] ? '0 : ctr_q + dim_t'(1);
                end
            end

            // R4
            ctr_range_chk: assert property (@(posedge clk) disable iff (rst)
                (advance && !at_top[i]) |-> (ctr_q < limits[i]));
        end
    endgenerate

    assign at_end = &at_top;

endmodule

// File: rtl/uop_index_calc.sv
module uop_index_calc
    import conv_uop_pkg::*;
#(
    parameter int IDX_W = 20
) (
    input  conv_geom_t       geom,
    input  loop_vec_t        count,
    output logic [IDX_W-1:0] dst,
    output logic [IDX_W-1:0] src,
    output logic [IDX_W-1:0] wgt
);

    typedef logic [IDX_W-1:0] idx_t;

    idx_t y, x, ky, kx, oc, ic;
    idx_t w, kh, kw, oct, ict, pad_w;

    always_comb begin
        y     = idx_t'(count[L_Y]);
        x     = idx_t'(count[L_X]);
        ky    = idx_t'(count[L_KY]);
        kx    = idx_t'(count[L_KX]);
        oc    = idx_t'(count[L_OC]);
        ic    = idx_t'(count[L_IC]);
        w     = idx_t'(geom.w);
        kh    = idx_t'(geom.kh);
        kw    = idx_t'(geom.kw);
        oct   = idx_t'(geom.oct);
        ict   = idx_t'(geom.ict);
        pad_w = w + kw - idx_t'(1);

        dst = (y * w + x) * oct + oc;
        src = ((y + ky) * pad_w + (x + kx)) * ict + ic;
        wgt = ((oc * kh + ky) * kw + kx) * ict + ic;
    end

endmodule

// File: rtl/conv_uop_seq.sv
module conv_uop_seq
    import conv_uop_pkg::*;
#(
    parameter int IDX_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIM_W-1:0] cfg_h,
    input  logic [DIM_W-1:0] cfg_w,
    input  logic [DIM_W-1:0] cfg_kh,
    input  logic [DIM_W-1:0] cfg_kw,
    input  logic [DIM_W-1:0] cfg_oct,
    input  logic [DIM_W-1:0] cfg_ict,
    output logic             busy,
    output logic             cfg_err,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [IDX_W-1:0] uop_dst,
    output logic [IDX_W-1:0] uop_src,
    output logic [IDX_W-1:0] uop_wgt,
    output logic             uop_last
);

    seq_state_t state_q;
    conv_geom_t geom_q, geom_in;
    loop_vec_t  count;
    logic       at_end, fire, accept, good;
    logic       err_q;

    assign geom_in = '{h: cfg_h, w: cfg_w, kh: cfg_kh, kw: cfg_kw,
                       oct: cfg_oct, ict: cfg_ict};
    assign accept  = start && (state_q == SEQ_IDLE);
    assign good    = !geom_is_bad(geom_in);
    assign fire    = uop_valid && uop_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            geom_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                geom_q <= geom_in;
                err_q  <= !good;
                if (good) state_q <= SEQ_RUN;
            end else if (fire && at_end) begin
                state_q <= SEQ_IDLE;
            end
        end
    end

    uop_loop_nest i_nest (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .advance (fire),
        .limits  (geom_limits(geom_q)),
        .count   (count),
        .at_end  (at_end)
    );

    uop_index_calc #(.IDX_W(IDX_W)) i_calc (
        .geom  (geom_q),
        .count (count),
        .dst   (uop_dst),
        .src   (uop_src),
        .wgt   (uop_wgt)
    );

    assign busy      = (state_q == SEQ_RUN);
    assign uop_valid = busy;
    assign uop_last  = busy && at_end;
    assign cfg_err   = err_q;

    // Previous transferred dst, for the hazard check
    logic [IDX_W-1:0] prev_dst_q;
    logic             have_prev_q;

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            have_prev_q <= 1'b0;
            prev_dst_q  <= '0;
        end else if (fire) begin
            have_prev_q <= !at_end;
            prev_dst_q  <= uop_dst;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!uop_valid && !busy && !cfg_err));

    // R6
    dst_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && have_prev_q) |-> (uop_dst != prev_dst_q));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready && !accept) |=>
            (uop_valid && $stable(uop_dst) && $stable(uop_src) &&
             $stable(uop_wgt) && $stable(uop_last)));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !uop_valid);

    // R10
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && uop_last) |=> (!busy && !uop_valid));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(fire && uop_last)) |=> busy);

endmodule

// File: tb/test_conv_uop_seq.sv
module test_conv_uop_seq;
    localparam int IDX_W = 20;
    localparam int DW    = 8;
    localparam int NCASE = 4;
    // h, w, kh, kw, oct, ict
    localparam int CASES [NCASE][6] = '{
        '{2, 3, 1, 1, 1, 1},
        '{1, 1, 3, 3, 2, 3},
        '{3, 2, 3, 1, 1, 2},
        '{9, 9, 3, 3, 4, 2}
    };

    logic clk = 0, rst = 1, start = 0, uop_ready = 0;
    logic [DW-1:0] cfg_h = 0, cfg_w = 0, cfg_kh = 0, cfg_kw = 0, cfg_oct = 0, cfg_ict = 0;
    logic busy, cfg_err, uop_valid, uop_last;
    logic [IDX_W-1:0] uop_dst, uop_src, uop_wgt;

    int checks = 0, failures = 0, cyc = 0, stall_ctr = 0;
    logic have_prev;
    logic [IDX_W-1:0] prev_dst;

    conv_uop_seq #(.IDX_W(IDX_W)) i_conv_uop_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_h(cfg_h), .cfg_w(cfg_w), .cfg_kh(cfg_kh), .cfg_kw(cfg_kw),
        .cfg_oct(cfg_oct), .cfg_ict(cfg_ict),
        .busy(busy), .cfg_err(cfg_err), .uop_valid(uop_valid),
        .uop_ready(uop_ready), .uop_dst(uop_dst), .uop_src(uop_src),
        .uop_wgt(uop_wgt), .uop_last(uop_last)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int h, w, kh, kw, oct, ict);
        cfg_h = DW'(h); cfg_w = DW'(w); cfg_kh = DW'(kh);
        cfg_kw = DW'(kw); cfg_oct = DW'(oct); cfg_ict = DW'(ict);
    endtask

    // Waits for a transfer, checking that stalled outputs hold (R7)
    task automatic wait_fire();
        logic stalled = 0;
        logic [IDX_W-1:0] sd = 0, ss = 0, sw = 0;
        logic sl = 0;
        forever begin
            @(negedge clk);
            start = 0;
            if (stalled) begin
                chk("R7 valid", uop_valid, 1);
                chk("R7 dst", uop_dst, sd);
                chk("R7 src", uop_src, ss);
                chk("R7 wgt", uop_wgt, sw);
                chk("R7 last", uop_last, sl);
            end
            uop_ready = (stall_ctr % 4) != 3;
            stall_ctr++;
            if (uop_valid && uop_ready) break;
            stalled = uop_valid;
            sd = uop_dst; ss = uop_src; sw = uop_wgt; sl = uop_last;
        end
    endtask

    task automatic run_case(input int h, w, kh, kw, oct, ict, input bit poke);
        int n = 0;
        int total = h * w * kh * kw * oct * ict;
        int pw = w + kw - 1;
        set_cfg(h, w, kh, kw, oct, ict);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0; uop_ready = 0;
        chk("R2 busy", busy, 1);
        chk("R2 valid", uop_valid, 1);
        chk("R8 err cleared", cfg_err, 0);
        chk("R2 first dst", uop_dst, 0);
        chk("R2 first src", uop_src, 0);
        chk("R2 first wgt", uop_wgt, 0);
        have_prev = 0;
        // R4 loop order: y, ky, kx, ic, x, oc
        for (int y = 0; y < h; y++)
        for (int ky = 0; ky < kh; ky++)
        for (int kx = 0; kx < kw; kx++)
        for (int ic = 0; ic < ict; ic++)
        for (int x = 0; x < w; x++)
        for (int oc = 0; oc < oct; oc++) begin
            wait_fire();
            chk("R3/R4 dst", uop_dst, (y * w + x) * oct + oc);
            chk("R3/R4 src", uop_src, ((y + ky) * pw + (x + kx)) * ict + ic);
            chk("R3/R4 wgt", uop_wgt, ((oc * kh + ky) * kw + kx) * ict + ic);
            chk("R5 last", uop_last, n == total - 1);
            if (have_prev) begin
                checks++;
                if (uop_dst == prev_dst) begin
                    failures++;
                    $display("FAIL R6: got dst %0d expected different from %0d", uop_dst, prev_dst);
                end
            end
            have_prev = 1; prev_dst = uop_dst;
            if (poke && n == 2) begin
                // R9: start while busy with another geometry
                start = 1;
                set_cfg(1, 2, 1, 1, 1, 1);
            end
            n++;
        end
        @(negedge clk);
        uop_ready = 0;
        chk("R5 count", n, total);
        chk("R10 busy low", busy, 0);
        chk("R10 valid low", uop_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", uop_valid, 0);
        chk("R1 busy", busy, 0);
        chk("R1 err", cfg_err, 0);
        rst = 0;

        for (int t = 0; t < NCASE; t++)
            run_case(CASES[t][0], CASES[t][1], CASES[t][2], CASES[t][3],
                     CASES[t][4], CASES[t][5], t == 2);

        // R8: w*OCt == 1 is refused
        set_cfg(3, 1, 3, 3, 1, 2);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R8 err set", cfg_err, 1);
        chk("R8 no valid", uop_valid, 0);
        repeat (3) @(negedge clk);
        chk("R8 still quiet", uop_valid, 0);
        chk("R8 err sticky", cfg_err, 1);

        // R8: zero field is refused
        set_cfg(0, 4, 3, 3, 2, 2);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R8 zero err", cfg_err, 1);
        chk("R8 zero busy", busy, 0);

        // R10: a new start after a refused one runs normally
        run_case(1, 2, 1, 2, 1, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule